// File: doc/BRIEF.md
# Processor Status Word Register

This block keeps the 16-bit status word of a small processor core. On every cycle in which the ALU presents a result with the update strobe raised, it derives six condition flags from that result. The flags are carry, parity, half carry, zero, sign and signed overflow. It uses the two operands, the adder's carry or borrow out and the operation width, either 8 or 16 bits. Three control flags sit beside them in the same word: single-step, interrupt enable and string direction. These change only through explicit set or clear commands or through a whole-word load, which is used to restore a saved status word.

The output is the packed word, read straight from the register. Flag bit positions are fixed because downstream decode depends on them. The unused positions are not stored and always read a parameterised constant.

Top module: `status_word_reg`

## Requirements
- R1: While reset is asserted and after it is released, before any update, the output word equals the reserved constant, default 16'h0002 (all flags 0).
- R2: On an update, bit 6 (zero) becomes 1 exactly when the result is zero over the operation width: the low 8 bits when `word_op`=0 and all 16 bits when `word_op`=1. Result bits above the width are ignored.
- R3: On an update, bit 7 (sign) takes the result's top bit for the width: bit 7 for byte operations and bit 15 for word operations.
- R4: On an update, bit 0 (carry) takes the value of `alu_carry`, the carry or borrow out of the top bit of the selected width.
- R5: On an update, bit 2 (parity) becomes 1 when the low 8 result bits hold an even number of ones, in either width.
- R6: On an update, bit 4 (half carry) becomes `op_a[4] ^ op_b[4] ^ alu_res[4]`, which is the carry or borrow from bit 3 into bit 4.
- R7: On an update, bit 11 (overflow) is 1 in two cases, using the top bits of the width. For an add (`sub_op`=0), it is 1 when the operands share a sign and the result's sign differs. For a subtract (`sub_op`=1), it is 1 when the operand signs differ and the result's sign differs from `op_a`.
- R8: Bit 9 (interrupt enable) is set by `int_set` and cleared by `int_clr`. When both are raised in one cycle, clear wins.
- R9: Bit 10 (direction: 0 means ascending addresses, 1 means descending) is set by `dir_set` and cleared by `dir_clr`. When both are raised in one cycle, clear wins.
- R10: An update never changes bits 8, 9 and 10. Without an update, bits 0, 2, 4, 6, 7 and 11 hold their values.
- R11: When `load_en` is high, every flag bit (0, 2, 4, 6, 7, 8, 9, 10, 11) takes the matching bit of `load_word` on the next edge. This overrides an update and any command in the same cycle. Bit 8 (single step) changes only this way.
- R12: Reserved positions (1, 3, 5, 12 to 15) always read the reserved constant, even after a load of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Recompute condition flags from the ALU inputs |
| word_op | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| sub_op | input | 1 | 1 = operation was a subtract (op_a - op_b) |
| op_a | input | 16 | First ALU operand |
| op_b | input | 16 | Second ALU operand |
| alu_res | input | 16 | ALU result |
| alu_carry | input | 1 | Carry/borrow out of the top bit of the selected width |
| int_set | input | 1 | Set interrupt-enable flag |
| int_clr | input | 1 | Clear interrupt-enable flag |
| dir_set | input | 1 | Set direction flag |
| dir_clr | input | 1 | Clear direction flag |
| load_en | input | 1 | Load all flags from load_word |
| load_word | input | 16 | Word to restore |
| flags_out | output | 16 | Packed status word |

## Verification
Byte and word additions are chosen to cross the signed boundary, wrap to zero with a carry, and carry out of bit 3. This separates the sign and overflow taps at bit 7 from those at bit 15, and separates the carry from the half carry. Subtractions that borrow show that the overflow rule switches with `sub_op`. A byte operation whose low byte is zero while its high byte is not confirms that zero detection honours the width. Command pairs issued alone, together and alongside updates or loads separate clear priority, load priority and the isolation between control and condition flags. A load of all ones and one of all zeros show that the reserved bits never move.

// File: rtl/status_word_pkg.sv
package status_word_pkg;

   localparam int SW_CF = 0;
   localparam int SW_PF = 2;
   localparam int SW_AF = 4;
   localparam int SW_ZF = 6;
   localparam int SW_SF = 7;
   localparam int SW_TF = 8;
   localparam int SW_IF = 9;
   localparam int SW_DF = 10;
   localparam int SW_OF = 11;

   localparam int SW_NCTRL = 3;
   localparam int SW_CTRL_TRAP = 0;
   localparam int SW_CTRL_INT  = 1;
   localparam int SW_CTRL_DIR  = 2;

   typedef struct packed {
      logic cf;
      logic pf;
      logic af;
      logic zf;
      logic sf;
      logic of;
   } cond_flags_t;

   function automatic logic [15:0] cond_mask();
      logic [15:0] m;
      m = '0;
      m[SW_CF] = 1'b1;
      m[SW_PF] = 1'b1;
      m[SW_AF] = 1'b1;
      m[SW_ZF] = 1'b1;
      m[SW_SF] = 1'b1;
      m[SW_OF] = 1'b1;
      return m;
   endfunction

   function automatic logic [15:0] ctrl_mask();
      logic [15:0] m;
      m = '0;
      m[SW_TF] = 1'b1;
      m[SW_IF] = 1'b1;
      m[SW_DF] = 1'b1;
      return m;
   endfunction

   function automatic cond_flags_t unpack_cond(input logic [15:0] w);
      cond_flags_t c;
      c.cf = w[SW_CF];
      c.pf = w[SW_PF];
      c.af = w[SW_AF];
      c.zf = w[SW_ZF];
      c.sf = w[SW_SF];
      c.of = w[SW_OF];
      return c;
   endfunction

   function automatic logic [15:0] pack_word(input cond_flags_t c,
                                             input logic [SW_NCTRL-1:0] k,
                                             input logic [15:0] rsvd);
      logic [15:0] w;
      w = rsvd & ~(cond_mask() | ctrl_mask());
      w[SW_CF] = c.cf;
      w[SW_PF] = c.pf;
      w[SW_AF] = c.af;
      w[SW_ZF] = c.zf;
      w[SW_SF] = c.sf;
      w[SW_OF] = c.of;
      w[SW_TF] = k[SW_CTRL_TRAP];
      w[SW_IF] = k[SW_CTRL_INT];
      w[SW_DF] = k[SW_CTRL_DIR];
      return w;
   endfunction

endpackage

// File: rtl/sw_cond_calc.sv
module sw_cond_calc
   import status_word_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic              word_op,
   input  logic              sub_op,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   input  logic [WORD_W-1:0] alu_res,
   input  logic              alu_carry,
   output cond_flags_t       cond
);

   localparam int HI_W = WORD_W - BYTE_W;

   logic a_top, b_top, r_top;
   logic lo_zero, hi_zero;
   logic same_in, flip_out;

   always_comb begin
      a_top   = word_op ? op_a[WORD_W-1]    : op_a[BYTE_W-1];
      b_top   = word_op ? op_b[WORD_W-1]    : op_b[BYTE_W-1];
      r_top   = word_op ? alu_res[WORD_W-1] : alu_res[BYTE_W-1];
      lo_zero = (alu_res[BYTE_W-1:0] == '0);
      hi_zero = (alu_res[WORD_W-1:BYTE_W] == {HI_W{1'b0}});
      // a subtract behaves as an add of the negated operand: invert b's sign
      same_in  = ~(a_top ^ (b_top ^ sub_op));
      flip_out = a_top ^ r_top;

      cond.cf = alu_carry;
      cond.pf = ~(^alu_res[BYTE_W-1:0]);
      cond.af = op_a[NIB_W] ^ op_b[NIB_W] ^ alu_res[NIB_W];
      cond.zf = lo_zero & (hi_zero | ~word_op);
      cond.sf = r_top;
      cond.of = same_in & flip_out;
   end

endmodule

// File: rtl/sw_ctrl_bit.sv
module sw_ctrl_bit #(
   parameter bit CLR_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_en,
   input  logic load_val,
   input  logic set_cmd,
   input  logic clr_cmd,
   output logic q
);

   logic nxt;

   generate
      if (CLR_WINS) begin : g_clr_first
         always_comb begin
            if (clr_cmd)      nxt = 1'b0;
            else if (set_cmd) nxt = 1'b1;
            else              nxt = q;
         end
      end else begin : g_set_first
         always_comb begin
            if (set_cmd)      nxt = 1'b1;
            else if (clr_cmd) nxt = 1'b0;
            else              nxt = q;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       q <= 1'b0;
      else if (load_en) q <= load_val;
      else              q <= nxt;
   end

   generate
      if (CLR_WINS) begin : g_chk
         a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_en && clr_cmd) |=> !q);
      end
   endgenerate

   a_r11_load_bit: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (q == $past(load_val)));

   a_r10_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !set_cmd && !clr_cmd) |=> $stable(q));

endmodule

// File: rtl/status_word_reg.sv
module status_word_reg
   import status_word_pkg::*;
#(
   parameter int          WORD_W     = 16,
   parameter int          BYTE_W     = 8,
   parameter int          NIB_W      = 4,
   parameter logic [15:0] RSVD_VALUE = 16'h0002,
   parameter bit          CLR_WINS   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic              word_op,
   input  logic              sub_op,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   input  logic [WORD_W-1:0] alu_res,
   input  logic              alu_carry,
   input  logic              int_set,
   input  logic              int_clr,
   input  logic              dir_set,
   input  logic              dir_clr,
   input  logic              load_en,
   input  logic [15:0]       load_word,
   output logic [15:0]       flags_out
);

   localparam logic [15:0] FLAG_BITS = cond_mask() | ctrl_mask();
   localparam logic [15:0] RSVD_BITS = ~FLAG_BITS;

   generate
      if (WORD_W != 16) begin : g_bad_word
         $error("status_word_reg: WORD_W must be 16 for the fixed flag layout");
      end
      if (BYTE_W <= NIB_W || BYTE_W >= WORD_W) begin : g_bad_byte
         $error("status_word_reg: need NIB_W < BYTE_W < WORD_W");
      end
      if ((RSVD_VALUE & FLAG_BITS) != 16'h0000) begin : g_bad_rsvd
         $error("status_word_reg: RSVD_VALUE overlaps flag positions");
      end
   endgenerate

   cond_flags_t              cond_calc;
   cond_flags_t              cond_q;
   logic [SW_NCTRL-1:0]      ctrl_q;
   logic [SW_NCTRL-1:0]      ctrl_set;
   logic [SW_NCTRL-1:0]      ctrl_clr;
   logic [SW_NCTRL-1:0]      ctrl_ld;

   sw_cond_calc #(
      .WORD_W(WORD_W),
      .BYTE_W(BYTE_W),
      .NIB_W (NIB_W)
   ) i_calc (
      .word_op  (word_op),
      .sub_op   (sub_op),
      .op_a     (op_a),
      .op_b     (op_b),
      .alu_res  (alu_res),
      .alu_carry(alu_carry),
      .cond     (cond_calc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       cond_q <= '0;
      else if (load_en) cond_q <= unpack_cond(load_word);
      else if (upd_en)  cond_q <= cond_calc;
   end

   always_comb begin
      ctrl_set = '0;
      ctrl_clr = '0;
      ctrl_set[SW_CTRL_INT] = int_set;
      ctrl_clr[SW_CTRL_INT] = int_clr;
      ctrl_set[SW_CTRL_DIR] = dir_set;
      ctrl_clr[SW_CTRL_DIR] = dir_clr;
      ctrl_ld[SW_CTRL_TRAP] = load_word[SW_TF];
      ctrl_ld[SW_CTRL_INT]  = load_word[SW_IF];
      ctrl_ld[SW_CTRL_DIR]  = load_word[SW_DF];
   end

   generate
      for (genvar g = 0; g < SW_NCTRL; g++) begin : g_ctrl
         sw_ctrl_bit #(.CLR_WINS(CLR_WINS)) i_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_en (load_en),
            .load_val(ctrl_ld[g]),
            .set_cmd (ctrl_set[g]),
            .clr_cmd (ctrl_clr[g]),
            .q       (ctrl_q[g])
         );
      end
   endgenerate

   assign flags_out = pack_word(cond_q, ctrl_q, RSVD_VALUE);

   // ---------------- assertions ----------------
   a_r12_rsvd_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_out & RSVD_BITS) == RSVD_VALUE);

   a_r11_load_all: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> ((flags_out & FLAG_BITS) == ($past(load_word) & FLAG_BITS)));

   a_r10_cond_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !upd_en) |=> ((flags_out & cond_mask()) == ($past(flags_out) & cond_mask())));

   a_r10_update_spares_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !int_set && !int_clr && !dir_set && !dir_clr)
      |=> ((flags_out & ctrl_mask()) == ($past(flags_out) & ctrl_mask())));

   a_r4_carry_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !load_en) |=> (flags_out[SW_CF] == $past(alu_carry)));

   a_r2_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !load_en && !word_op && alu_res[BYTE_W-1:0] == '0) |=> flags_out[SW_ZF]);

   a_r3_word_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !load_en && word_op) |=> (flags_out[SW_SF] == $past(alu_res[WORD_W-1])));

   a_r8_int_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && int_set && !int_clr) |=> flags_out[SW_IF]);

   a_r9_dir_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && dir_clr && CLR_WINS) |=> !flags_out[SW_DF]);

endmodule

// File: tb/test_status_word_reg.sv
`timescale 1ns/1ps
module test_status_word_reg;

   typedef struct {
      logic [15:0] exp;
      string       tag;
   } exp_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_en = 1'b0, word_op = 1'b0, sub_op = 1'b0, alu_carry = 1'b0;
   logic [15:0] op_a = '0, op_b = '0, alu_res = '0, load_word = '0;
   logic        int_set = 1'b0, int_clr = 1'b0, dir_set = 1'b0, dir_clr = 1'b0;
   logic        load_en = 1'b0;
   logic [15:0] flags_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   exp_item_t sb[$];
   logic [15:0] m_word = 16'h0000;

   localparam logic [15:0] RSVD   = 16'h0002;
   localparam logic [15:0] M_COND = 16'h08D5;
   localparam logic [15:0] M_ALL  = 16'h0FD5;

   always #2 clk = ~clk;

   status_word_reg i_status_word_reg (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .word_op(word_op), .sub_op(sub_op),
      .op_a(op_a), .op_b(op_b), .alu_res(alu_res), .alu_carry(alu_carry),
      .int_set(int_set), .int_clr(int_clr), .dir_set(dir_set), .dir_clr(dir_clr),
      .load_en(load_en), .load_word(load_word), .flags_out(flags_out)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: each result appears one edge after its stimulus
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_item_t it;
         it = sb.pop_front();
         check(it.tag, flags_out, it.exp);
      end
   end

   task automatic idle();
      upd_en = 0; load_en = 0; int_set = 0; int_clr = 0; dir_set = 0; dir_clr = 0;
   endtask

   // driver: model the next word from the requirements and queue it
   task automatic commit(input string tag);
      logic [15:0] nxt;
      logic at, bt, rt;
      nxt = m_word;
      if (load_en) nxt = load_word & M_ALL;
      else begin
         if (upd_en) begin
            at = word_op ? op_a[15] : op_a[7];
            bt = word_op ? op_b[15] : op_b[7];
            rt = word_op ? alu_res[15] : alu_res[7];
            nxt = nxt & ~M_COND;
            nxt[0]  = alu_carry;
            nxt[2]  = ($countones(alu_res[7:0]) % 2) == 0;
            nxt[4]  = op_a[4] ^ op_b[4] ^ alu_res[4];
            nxt[6]  = word_op ? (alu_res == 16'h0) : (alu_res[7:0] == 8'h0);
            nxt[7]  = rt;
            nxt[11] = sub_op ? ((at != bt) && (rt != at)) : ((at == bt) && (rt != at));
         end
         if (int_clr) nxt[9] = 1'b0; else if (int_set) nxt[9] = 1'b1;
         if (dir_clr) nxt[10] = 1'b0; else if (dir_set) nxt[10] = 1'b1;
      end
      m_word = nxt;
      sb.push_back('{exp: nxt | RSVD, tag: tag});
      @(negedge clk);
      idle();
   endtask

   task automatic alu(input logic w, input logic s, input logic [15:0] a,
                      input logic [15:0] b, input string tag);
      logic [16:0] full;
      logic [8:0]  lo;
      full = s ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
      lo   = s ? ({1'b0, a[7:0]} - {1'b0, b[7:0]}) : ({1'b0, a[7:0]} + {1'b0, b[7:0]});
      word_op = w; sub_op = s; op_a = a; op_b = b;
      alu_res = full[15:0];
      alu_carry = w ? full[16] : lo[8];
      upd_en = 1'b1;
      commit(tag);
   endtask

   initial begin
      #50000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 during reset", flags_out, RSVD);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", flags_out, RSVD);

      alu(1'b0, 1'b0, 16'h007F, 16'h0001, "R7 R3 R6 byte add signed overflow");
      alu(1'b0, 1'b0, 16'h00FF, 16'h0001, "R4 R2 byte add wraps to zero");
      alu(1'b0, 1'b0, 16'h1200, 16'h3400, "R2 byte zero ignores high byte");
      alu(1'b1, 1'b0, 16'h1200, 16'h3400, "R2 word nonzero");
      alu(1'b1, 1'b0, 16'h7FFF, 16'h0001, "R3 R7 word add overflow at bit15");
      alu(1'b1, 1'b1, 16'h0000, 16'h0001, "R4 R5 word subtract borrow");
      alu(1'b0, 1'b1, 16'h0080, 16'h0001, "R7 byte subtract overflow");
      alu(1'b0, 1'b0, 16'h0003, 16'h0000, "R5 parity even count");
      alu(1'b0, 1'b0, 16'h0001, 16'h0000, "R5 parity odd count");
      alu(1'b0, 1'b0, 16'h0008, 16'h0008, "R6 half carry from bit3");

      int_set = 1; commit("R8 interrupt set");
      dir_set = 1; commit("R9 direction set");
      alu(1'b1, 1'b0, 16'h8000, 16'h8000, "R10 update leaves control flags");
      commit("R10 idle holds all flags");
      int_set = 1; int_clr = 1; commit("R8 set and clear: clear wins");
      dir_set = 1; dir_clr = 1; commit("R9 set and clear: clear wins");
      dir_set = 1; commit("R9 direction set again");
      dir_clr = 1; commit("R9 direction clear");

      load_word = 16'hFFFF; load_en = 1; commit("R11 R12 load all ones");
      load_word = 16'h0000; load_en = 1; int_set = 1; dir_set = 1;
      word_op = 0; sub_op = 0; op_a = 16'h007F; op_b = 16'h0001; alu_res = 16'h0080;
      alu_carry = 1; upd_en = 1;
      commit("R11 load overrides update and commands");
      load_word = 16'h0100; load_en = 1; commit("R11 single-step restored by load");
      int_clr = 1; dir_clr = 1; commit("R11 single-step unaffected by commands");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule